// File: doc/BRIEF.md
# Dual Event Counter Monitor

The block watches a bus of event lanes and counts chosen events on two 40-bit counters. Each counter has a 32-bit control word that names an event class and a sub-event mask. The same word sets a threshold, an inversion and an edge qualifier, and chooses what the counter's output pin shows. Software writes the control words and the counters over a small register port and reads them back on the same port. A counter that wraps raises an interrupt pulse and sets a flag that stays set.

There is only one run/stop bit for the whole block, and it lives in counter 0's control word. To park a single counter while the other keeps running, software selects the event class with code 0x2E and a zero sub-event mask. That selection never counts. A few event classes are tied to one counter and count nothing when placed on the other.

Top module: `evmon_pair`

## Requirements
- R1: After reset both control words, both counters and both overflow flags read zero, `ovf_irq` is low and `pm_pin` is zero.
- R2: Control word layout: event code [7:0], sub-event mask [15:8], edge qualifier [18], pin mode [19], run bit [22], invert [23], threshold [31:24]. The other bits are kept and read back. Address 0 writes and reads counter 0's word, address 1 counter 1's. A write takes effect at the next clock edge.
- R3: Counting happens only while bit 22 of counter 0's word is set, and that bit gates both counters. Bit 22 of counter 1's word has no effect on counting.
- R4: Address 2+2i is the low 32 bits of counter i. Writing it loads bits 31:0 and copies bit 31 into bits 39:32. Address 3+2i reads {overflow flag in bit 31, zeros, counter bits 39:32}. Writes to 3+2i are ignored.
- R5: Event lanes are grouped four per class; class k uses `ev_lanes[4k+3:4k]`. The classes, by code: 0x79→0, 0xC0→1, 0x2E→2, 0xC4→3, 0xC1→4, 0x10→5, 0x14→6, 0x11→7, 0x12→8, 0x13→9. With threshold zero, a counter adds the number of set lanes of its class in each cycle. Only class 0x2E ANDs its lanes with mask bits 3:0. Any other code counts nothing.
- R6: Code 0x2E with a mask of 0x00 never increments its counter, whatever the invert, edge and threshold settings.
- R7: Codes 0xC1, 0x10 and 0x14 count only on counter 0. Codes 0x11, 0x12 and 0x13 count only on counter 1. On the other counter they never increment it, even with invert set.
- R8: With a nonzero threshold, the counter adds 1 when the lane count is at least the threshold. With invert set, it adds 1 when the lane count is below the threshold instead.
- R9: With edge set and a nonzero threshold, the counter adds 1 only in a cycle where the threshold condition is true and was false in the previous cycle. The condition is tracked every cycle.
- R10: When a counter wraps past all ones, `ovf_irq` is high for exactly the next cycle and the counter's flag becomes set. A write to that counter's low address clears the flag.
- R11: A counter write in the same cycle as an increment wins: the counter takes the written value, and no wrap or pulse comes from that cycle.
- R12: With pin mode 0, `pm_pin[i]` is high in the cycle after counter i was incremented. With pin mode 1, it is high in the cycle after counter i wrapped. It is low after a write to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_lanes | input | 40 | Event lanes, four per class |
| ovf_irq | output | 1 | Overflow interrupt pulse |
| pm_pin | output | 2 | Per-counter event/overflow indication |

## Verification
The bench aims at the parking selection 0x2E/0x00 with invert and a threshold set. A design that checks only the lane count would then count every cycle. It places counter-bound codes on the wrong counter, sets bit 22 only in counter 1's word, and loads values with bit 31 set. Those catch a missing restriction, a per-counter enable, and a load that zero-fills the top byte instead of sign-extending. It also drives wraps from sign-extended near-all-ones values, writes in the same cycle as an increment, and runs edge sequences. A wrong wrap detection, a pulse longer than one cycle, an increment that beats the write, or an edge qualifier that counts levels all show up as count or `ovf_irq` mismatches.

// File: rtl/evmon_pkg.sv
package evmon_pkg;

  localparam int NCTR    = 2;
  localparam int LANES   = 4;
  localparam int NCLS    = 10;
  localparam int EV_W    = NCLS * LANES;
  localparam int CNT_W   = 40;
  localparam int PROG_W  = 32;
  localparam int HI_W    = CNT_W - PROG_W;
  localparam int INC_W   = $clog2(LANES + 1);
  localparam int CLS_W   = $clog2(NCLS);
  localparam int ADDR_W  = 3;

  localparam logic [7:0] CODE_PARK = 8'h2E;

  typedef struct packed {
    logic [7:0] thresh;
    logic       invert;
    logic       run;
    logic [1:0] spare_hi;
    logic       pin_mode;
    logic       edge_q;
    logic [1:0] spare_lo;
    logic [7:0] submask;
    logic [7:0] code;
  } ctl_t;

  typedef enum logic [1:0] {
    BIND_ANY  = 2'd0,
    BIND_CTR0 = 2'd1,
    BIND_CTR1 = 2'd2
  } bind_e;

  typedef struct packed {
    logic             known;
    logic [CLS_W-1:0] cls;
    logic             masked;
    bind_e            bind_to;
  } cls_info_t;

  function automatic cls_info_t class_of(input logic [7:0] code);
    cls_info_t r;
    r = '{known: 1'b0, cls: '0, masked: 1'b0, bind_to: BIND_ANY};
    case (code)
      8'h79: r = '{1'b1, CLS_W'(0), 1'b0, BIND_ANY};
      8'hC0: r = '{1'b1, CLS_W'(1), 1'b0, BIND_ANY};
      8'h2E: r = '{1'b1, CLS_W'(2), 1'b1, BIND_ANY};
      8'hC4: r = '{1'b1, CLS_W'(3), 1'b0, BIND_ANY};
      8'hC1: r = '{1'b1, CLS_W'(4), 1'b0, BIND_CTR0};
      8'h10: r = '{1'b1, CLS_W'(5), 1'b0, BIND_CTR0};
      8'h14: r = '{1'b1, CLS_W'(6), 1'b0, BIND_CTR0};
      8'h11: r = '{1'b1, CLS_W'(7), 1'b0, BIND_CTR1};
      8'h12: r = '{1'b1, CLS_W'(8), 1'b0, BIND_CTR1};
      8'h13: r = '{1'b1, CLS_W'(9), 1'b0, BIND_CTR1};
      default: r = '{known: 1'b0, cls: '0, masked: 1'b0, bind_to: BIND_ANY};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/evmon_dec.sv
module evmon_dec
  import evmon_pkg::*;
#(
  parameter int CTR_IDX = 0
) (
  input  ctl_t              ctl,
  input  logic [EV_W-1:0]   ev_lanes,
  output logic [INC_W-1:0]  raw_o,
  output logic              valid_o
);

  localparam bind_e MY_BIND = (CTR_IDX == 0) ? BIND_CTR0 : BIND_CTR1;

  cls_info_t        info;
  logic [LANES-1:0] picked;
  logic [LANES-1:0] active;
  logic             allowed;
  logic             parked;

  always_comb begin
    info    = class_of(ctl.code);
    picked  = ev_lanes[info.cls*LANES +: LANES];
    active  = info.masked ? (picked & ctl.submask[LANES-1:0]) : picked;
    allowed = (info.bind_to == BIND_ANY) || (info.bind_to == MY_BIND);
    parked  = (ctl.code == CODE_PARK) && (ctl.submask == 8'h00);
    valid_o = info.known && allowed && !parked;
  end

  always_comb begin
    raw_o = '0;
    for (int k = 0; k < LANES; k++) begin
      raw_o = raw_o + INC_W'(active[k]);
    end
  end

endmodule

// File: rtl/evmon_qual.sv
module evmon_qual
  import evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  raw,
  input  logic              valid,
  input  logic              gate_en,
  input  logic [7:0]        thresh,
  input  logic              invert,
  input  logic              edge_q,
  output logic [INC_W-1:0]  inc_o
);

  logic       prev_q;
  logic       prev_d;
  logic       use_thr;
  logic       cond;
  logic       hit;
  logic [7:0] raw_ext;

  always_comb begin
    raw_ext = 8'(raw);
    use_thr = (thresh != 8'h00);
    cond    = valid && (invert ? (raw_ext < thresh) : (raw_ext >= thresh));
    hit     = edge_q ? (cond && !prev_q) : cond;
    prev_d  = use_thr && cond;
    if (!gate_en) begin
      inc_o = '0;
    end else if (use_thr) begin
      inc_o = INC_W'(hit);
    end else begin
      inc_o = valid ? raw : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/evmon_ctr.sv
module evmon_ctr
  import evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PROG_W-1:0] wr_data,
  input  logic [INC_W-1:0]  inc,
  input  logic              pin_on_wrap,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              flag_o,
  output logic              pulse_o,
  output logic              pin_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;
  logic             cnt_ce;
  logic             wrap;
  logic             flag_q, flag_d;
  logic             pulse_q, pulse_d;
  logic             pin_q, pin_d;

  always_comb begin
    sum     = {1'b0, cnt_q} + (CNT_W + 1)'(inc);
    wrap    = !wr_en && sum[CNT_W];
    cnt_ce  = wr_en || (inc != '0);
    cnt_d   = wr_en ? {{HI_W{wr_data[PROG_W-1]}}, wr_data} : sum[CNT_W-1:0];
    flag_d  = wr_en ? 1'b0 : (flag_q || wrap);
    pulse_d = wrap;
    if (wr_en) begin
      pin_d = 1'b0;
    end else if (pin_on_wrap) begin
      pin_d = wrap;
    end else begin
      pin_d = (inc != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (cnt_ce) begin
        cnt_q <= cnt_d;
      end
      flag_q  <= flag_d;
      pulse_q <= pulse_d;
      pin_q   <= pin_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign flag_o  = flag_q;
  assign pulse_o = pulse_q;
  assign pin_o   = pin_q;

endmodule

// File: rtl/evmon_pair.sv
module evmon_pair
  import evmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EV_W-1:0]   ev_lanes,
  output logic              ovf_irq,
  output logic [NCTR-1:0]   pm_pin
);

  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  ctl_t             ctl_q [NCTR];
  ctl_t             ctl_d [NCTR];
  logic [NCTR-1:0]  ctl_ce;
  logic [CNT_W-1:0] cnt_w [NCTR];
  logic [NCTR-1:0]  ovf_flag;
  logic [NCTR-1:0]  ovf_pulse;
  logic [NCTR-1:0]  cnt_wr;
  logic             run_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync_q[1];

  always_comb begin
    for (int i = 0; i < NCTR; i++) begin
      ctl_ce[i] = bus_wen && (bus_addr == ADDR_W'(i));
      ctl_d[i]  = ctl_t'(bus_wdata);
      cnt_wr[i] = bus_wen && (bus_addr == ADDR_W'(NCTR + 2*i));
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      for (int i = 0; i < NCTR; i++) begin
        ctl_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCTR; i++) begin
        if (ctl_ce[i]) begin
          ctl_q[i] <= ctl_d[i];
        end
      end
    end
  end

  assign run_all = ctl_q[0].run;

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    logic [INC_W-1:0] raw;
    logic             valid;
    logic [INC_W-1:0] inc;

    evmon_dec #(.CTR_IDX(g)) u_dec (
      .ctl      (ctl_q[g]),
      .ev_lanes (ev_lanes),
      .raw_o    (raw),
      .valid_o  (valid)
    );

    evmon_qual u_qual (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .raw     (raw),
      .valid   (valid),
      .gate_en (run_all),
      .thresh  (ctl_q[g].thresh),
      .invert  (ctl_q[g].invert),
      .edge_q  (ctl_q[g].edge_q),
      .inc_o   (inc)
    );

    evmon_ctr u_ctr (
      .clk         (clk),
      .rst_n       (rst_s_n),
      .wr_en       (cnt_wr[g]),
      .wr_data     (bus_wdata),
      .inc         (inc),
      .pin_on_wrap (ctl_q[g].pin_mode),
      .cnt_o       (cnt_w[g]),
      .flag_o      (ovf_flag[g]),
      .pulse_o     (ovf_pulse[g]),
      .pin_o       (pm_pin[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCTR; i++) begin
      if (bus_addr == ADDR_W'(i)) begin
        bus_rdata = ctl_q[i];
      end
      if (bus_addr == ADDR_W'(NCTR + 2*i)) begin
        bus_rdata = cnt_w[i][PROG_W-1:0];
      end
      if (bus_addr == ADDR_W'(NCTR + 2*i + 1)) begin
        bus_rdata = {ovf_flag[i], {(PROG_W-1-HI_W){1'b0}}, cnt_w[i][CNT_W-1:PROG_W]};
      end
    end
  end

  assign ovf_irq = |ovf_pulse;

endmodule

// File: rtl/evmon_pair_chk.sv
module evmon_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wen,
  input logic [2:0]  bus_addr,
  input logic [31:0] ctl0,
  input logic [31:0] ctl1,
  input logic [39:0] cnt0,
  input logic [39:0] cnt1,
  input logic [1:0]  pulse,
  input logic [1:0]  flag
);

  // R4: a low-word write leaves the top byte equal to copies of bit 31
  p_sext_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wen && bus_addr == 3'd2) |-> (cnt0[39:32] == {8{cnt0[31]}}));

  // R3: with the shared run bit clear, counters only change by writes
  p_halt_ctr0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl0[22] && !(bus_wen && bus_addr == 3'd2)) |-> (cnt0 == $past(cnt0)));

  p_halt_ctr1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctl0[22] && !(bus_wen && bus_addr == 3'd4)) |-> (cnt1 == $past(cnt1)));

  // R6: the parking selection holds the counter
  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl1[7:0] == 8'h2E && ctl1[15:8] == 8'h00 && !(bus_wen && bus_addr == 3'd4))
    |-> (cnt1 == $past(cnt1)));

  // R7: a counter-0-only code on counter 1 never counts
  p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl1[7:0] == 8'hC1 && !(bus_wen && bus_addr == 3'd4)) |-> (cnt1 == $past(cnt1)));

  // R10: wrap pulse lasts one cycle and always comes with the flag
  p_pulse_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse[0] |=> !pulse[0]);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse[1] |-> flag[1]);

endmodule

bind evmon_pair evmon_pair_chk u_evmon_pair_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wen  (bus_wen),
  .bus_addr (bus_addr),
  .ctl0     (ctl_q[0]),
  .ctl1     (ctl_q[1]),
  .cnt0     (cnt_w[0]),
  .cnt1     (cnt_w[1]),
  .pulse    (ovf_pulse),
  .flag     (ovf_flag)
);

// File: tb/test_evmon_pair.sv
module test_evmon_pair;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_wen;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [39:0] ev_lanes;
  logic        ovf_irq;
  logic [1:0]  pm_pin;

  int n_checks = 0;
  int n_fail   = 0;

  logic [31:0] m_ctl   [2];
  logic [39:0] m_cnt   [2];
  logic        m_prev  [2];
  logic        m_flag  [2];
  logic        m_pulse [2];
  logic        m_pin   [2];

  evmon_pair i_evmon_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_lanes  (ev_lanes),
    .ovf_irq   (ovf_irq),
    .pm_pin    (pm_pin)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  task automatic check(input string tag, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Event class table per R5/R7: returns class index, masking and binding
  function automatic void class_tab(input logic [7:0] c, output bit known,
                                    output int cls, output bit masked, output int only);
    known = 1'b1; masked = 1'b0; only = 0; cls = 0;
    case (c)
      8'h79: cls = 0;
      8'hC0: cls = 1;
      8'h2E: begin cls = 2; masked = 1'b1; end
      8'hC4: cls = 3;
      8'hC1: begin cls = 4; only = 1; end
      8'h10: begin cls = 5; only = 1; end
      8'h14: begin cls = 6; only = 1; end
      8'h11: begin cls = 7; only = 2; end
      8'h12: begin cls = 8; only = 2; end
      8'h13: begin cls = 9; only = 2; end
      default: known = 1'b0;
    endcase
  endfunction

  function automatic void expect_inc(input int i, input logic [39:0] ev,
                                     output int add, output bit cond_next);
    logic [31:0] s;
    bit known, masked, valid, cond;
    int cls, only, raw;
    logic [3:0] l;
    s = m_ctl[i];
    class_tab(s[7:0], known, cls, masked, only);
    l = ev[cls*4 +: 4];
    if (masked) l = l & s[11:8];
    raw = $countones(l);
    valid = known && (only == 0 || only == i + 1) && !(s[7:0] == 8'h2E && s[15:8] == 8'h00);
    cond = valid && (s[23] ? (raw < int'(s[31:24])) : (raw >= int'(s[31:24])));
    cond_next = (s[31:24] != 8'h00) && cond;
    if (!m_ctl[0][22]) add = 0;
    else if (s[31:24] != 8'h00) add = (s[18] ? (cond && !m_prev[i]) : cond) ? 1 : 0;
    else add = valid ? raw : 0;
  endfunction

  task automatic compare_all(input string tag);
    check(tag, "ovf_irq", 40'(ovf_irq), 40'(m_pulse[0] | m_pulse[1]));
    check(tag, "pm_pin0", 40'(pm_pin[0]), 40'(m_pin[0]));
    check(tag, "pm_pin1", 40'(pm_pin[1]), 40'(m_pin[1]));
    bus_wen = 1'b0;
    for (int a = 0; a < 6; a++) begin
      logic [31:0] e;
      bus_addr = 3'(a);
      #0.5;
      case (a)
        0: e = m_ctl[0];
        1: e = m_ctl[1];
        2: e = m_cnt[0][31:0];
        3: e = {m_flag[0], 23'd0, m_cnt[0][39:32]};
        4: e = m_cnt[1][31:0];
        default: e = {m_flag[1], 23'd0, m_cnt[1][39:32]};
      endcase
      check(tag, $sformatf("read addr %0d", a), 40'(bus_rdata), 40'(e));
    end
  endtask

  task automatic cyc(input logic wen, input logic [2:0] addr, input logic [31:0] wd,
                     input logic [39:0] ev, input string tag);
    logic [39:0] n_cnt [2];
    logic n_prev [2], n_flag [2], n_pulse [2], n_pin [2];
    @(negedge clk);
    bus_wen = wen; bus_addr = addr; bus_wdata = wd; ev_lanes = ev;
    for (int i = 0; i < 2; i++) begin
      int add;
      bit cn;
      logic [40:0] sum;
      expect_inc(i, ev, add, cn);
      n_prev[i] = cn;
      if (wen && addr == 3'(2 + 2*i)) begin
        n_cnt[i] = {{8{wd[31]}}, wd};
        n_flag[i] = 1'b0; n_pulse[i] = 1'b0; n_pin[i] = 1'b0;
      end else begin
        sum = {1'b0, m_cnt[i]} + 41'(add);
        n_cnt[i] = sum[39:0];
        n_pulse[i] = sum[40];
        n_flag[i] = m_flag[i] | sum[40];
        n_pin[i] = m_ctl[i][19] ? sum[40] : (add != 0);
      end
    end
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = n_cnt[i]; m_prev[i] = n_prev[i]; m_flag[i] = n_flag[i];
      m_pulse[i] = n_pulse[i]; m_pin[i] = n_pin[i];
      if (wen && addr == 3'(i)) m_ctl[i] = wd;
    end
    #1;
    compare_all(tag);
  endtask

  function automatic logic [39:0] lane(input int cls, input logic [3:0] v);
    logic [39:0] r;
    r = '0;
    r[cls*4 +: 4] = v;
    return r;
  endfunction

  function automatic logic [31:0] rand_ctl(input bit is0);
    logic [7:0] codes [12];
    logic [31:0] w;
    codes = '{8'h79, 8'hC0, 8'h2E, 8'hC4, 8'hC1, 8'h10, 8'h14,
              8'h11, 8'h12, 8'h13, 8'h55, 8'h00};
    w = $urandom();
    w[7:0]   = codes[$urandom_range(11)];
    w[15:8]  = ($urandom_range(3) == 0) ? 8'h00 : 8'($urandom_range(15));
    w[31:24] = ($urandom_range(1) == 0) ? 8'h00 : 8'($urandom_range(4));
    w[23]    = ($urandom_range(3) == 0);
    w[18]    = ($urandom_range(3) == 0);
    if (is0) w[22] = ($urandom_range(9) != 0);
    return w;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    bus_wen = 1'b0; bus_addr = '0; bus_wdata = '0; ev_lanes = '0;
    for (int i = 0; i < 2; i++) begin
      m_ctl[i] = '0; m_cnt[i] = '0; m_prev[i] = 1'b0;
      m_flag[i] = 1'b0; m_pulse[i] = 1'b0; m_pin[i] = 1'b0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    cyc(1'b0, 3'd0, 32'd0, 40'd0, "R1");

    // R2: control words load and read back whole
    cyc(1'b1, 3'd0, 32'h0043_0079, 40'd0, "R2");
    cyc(1'b1, 3'd1, 32'h0003_0FC0, 40'd0, "R2");

    // R5: plain lane counts; class 0x2E masked by submask
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1) | lane(1, 4'hB), "R5");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1) | lane(1, 4'hF), "R5");
    cyc(1'b1, 3'd1, 32'h0000_0F2E, lane(1, 4'h3), "R5");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'hF), "R5");
    cyc(1'b1, 3'd1, 32'h0000_012E, 40'd0, "R5");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'hF), "R5");
    cyc(1'b1, 3'd1, 32'h0000_0055, 40'd0, "R5");
    cyc(1'b0, 3'd7, 32'd0, 40'hFF_FFFF_FFFF, "R5");

    // R3: run bit only in counter 0's word
    cyc(1'b1, 3'd1, 32'h0040_00C0, 40'd0, "R3");
    cyc(1'b1, 3'd0, 32'h0000_0079, 40'd0, "R3");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1) | lane(1, 4'hF), "R3");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1) | lane(1, 4'hF), "R3");
    cyc(1'b1, 3'd0, 32'h0040_0079, 40'd0, "R3");

    // R6: parking selection with invert and threshold
    cyc(1'b1, 3'd1, 32'h0180_002E, 40'd0, "R6");
    cyc(1'b0, 3'd7, 32'd0, 40'd0, "R6");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'hF), "R6");

    // R7: counter-bound codes on the wrong counter, with invert
    cyc(1'b1, 3'd0, 32'h0140_0011, 40'd0, "R7");
    cyc(1'b1, 3'd1, 32'h0180_00C1, lane(7, 4'hF), "R7");
    cyc(1'b0, 3'd7, 32'd0, lane(4, 4'hF) | lane(7, 4'hF), "R7");
    cyc(1'b1, 3'd0, 32'h0040_0014, 40'd0, "R7");
    cyc(1'b1, 3'd1, 32'h0000_0013, lane(6, 4'h3), "R7");
    cyc(1'b0, 3'd7, 32'd0, lane(6, 4'h3) | lane(9, 4'h5), "R7");

    // R8: threshold and inverted threshold
    cyc(1'b1, 3'd0, 32'h0240_0F2E, 40'd0, "R8");
    cyc(1'b1, 3'd1, 32'h0280_0FC0, lane(2, 4'h1), "R8");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'h3) | lane(1, 4'h1), "R8");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'hF) | lane(1, 4'h7), "R8");

    // R9: edge on threshold condition
    cyc(1'b1, 3'd0, 32'h0244_0F2E, 40'd0, "R9");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'h7), "R9");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'h7), "R9");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'h0), "R9");
    cyc(1'b0, 3'd7, 32'd0, lane(2, 4'hF), "R9");

    // R4: sign-extended load, high address write ignored
    cyc(1'b1, 3'd2, 32'h8000_0001, 40'd0, "R4");
    cyc(1'b1, 3'd3, 32'h0000_0012, 40'd0, "R4");
    cyc(1'b1, 3'd4, 32'h7FFF_FFFF, 40'd0, "R4");

    // R10/R12: wrap, one-cycle pulse, sticky flag, pin on wrap
    cyc(1'b1, 3'd1, 32'h0008_0079, 40'd0, "R12");
    cyc(1'b1, 3'd4, 32'hFFFF_FFFE, 40'd0, "R10");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1), "R10");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1), "R10");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1), "R10");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1), "R12");
    cyc(1'b1, 3'd4, 32'h0000_0005, lane(0, 4'h1), "R10");

    // R11: write beats increment and a would-be wrap
    cyc(1'b1, 3'd4, 32'hFFFF_FFFF, 40'd0, "R11");
    cyc(1'b1, 3'd4, 32'h0000_0100, lane(0, 4'h1), "R11");
    cyc(1'b0, 3'd7, 32'd0, lane(0, 4'h1), "R11");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      int pick;
      logic [39:0] ev;
      ev = {8'($urandom()), 32'($urandom())};
      pick = $urandom_range(19);
      if (pick == 0)      cyc(1'b1, 3'd0, rand_ctl(1'b1), ev, "R5");
      else if (pick == 1) cyc(1'b1, 3'd1, rand_ctl(1'b0), ev, "R5");
      else if (pick == 2) cyc(1'b1, 3'(2 + 2*$urandom_range(1)),
                              32'hFFFF_FFF0 | 32'($urandom_range(15)), ev, "R10");
      else if (pick == 3) cyc(1'b1, 3'(2 + 2*$urandom_range(1)), $urandom(), ev, "R4");
      else                cyc(1'b0, 3'd7, 32'd0, ev, "R5");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule